// File: doc/BRIEF.md
# Parallel Complex Correlator with Sign Slicer

This block turns despread complex samples back into data bits. Eight lanes run side by side, one for each parallel data bit. Each lane keeps the sixteen most recently accepted samples, with the real part and the imaginary part in separate shift histories. A single shared trigger makes every lane sum its window through a pipelined binary adder tree at the same moment. The real part of each lane's sum is then compared with zero to give one bit.

Both the real and the imaginary window sums appear at the ports with the bits, so the correlation itself can be observed. A small two-state controller tracks whether the histories have been filled since reset. Its state FILL becomes READY when the sixteenth sample is accepted, and READY holds until reset. A decision taken while the controller is still in FILL is flagged as unprimed.

Top module: `cplx_corr_decide`

## Requirements
- R1: There are 8 lanes. Lane l takes its sample from bits [l*24 +: 24] of the real and imaginary input buses. Each sample is a signed 24-bit fixed-point value with 16 fractional bits, and each lane's history is independent of the others.
- R2: A lane's history advances only in a cycle where `smp_vld` is high. The new sample enters and the oldest of the 16 is dropped. When `smp_vld` is low, the history and every later sum are unaffected by the input buses.
- R3: For each lane, the reported real and imaginary sums are the exact signed 28-bit totals of the 16 stored values. All-maximum and all-minimum windows do not overflow. Lane l's sums sit at bits [l*28 +: 28].
- R4: `bits_out[l]` is 1 when lane l's real sum is strictly greater than zero. It is 0 when the sum is zero or negative.
- R5: If `sum_go` is sampled high at rising edge k, the results and a high `bits_vld` become visible after edge k+4. They are computed over the history as it stood before edge k, so a sample accepted at edge k itself is not included.
- R6: `bits_vld` is a one-cycle pulse for each sampled `sum_go`, and triggers on consecutive cycles each produce a result. Between pulses, the bits, sums and flag hold their last values.
- R7: `bits_unprimed` is 1 on a result whose trigger came while fewer than 16 samples had been accepted since reset (controller in FILL), and 0 otherwise (READY).
- R8: While `rst_n` is low, the histories are cleared, the controller returns to FILL, and every output is 0.
- R9: All lanes are triggered by the one `sum_go` and report in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Input samples valid, advances histories |
| smp_re | input | 192 | Real parts, 8 lanes x 24 bits |
| smp_im | input | 192 | Imaginary parts, 8 lanes x 24 bits |
| sum_go | input | 1 | Shared trigger to sum all windows |
| bits_out | output | 8 | Decided bits, one per lane |
| bits_vld | output | 1 | One-cycle strobe marking new results |
| bits_unprimed | output | 1 | Result taken before the histories were full |
| corr_sum_re | output | 224 | Real window sums, 8 lanes x 28 bits |
| corr_sum_im | output | 224 | Imaginary window sums, 8 lanes x 28 bits |

## Verification
A stale or wrongly shifted history entry shows up as a wrong window sum on the very next result, five cycles after the trigger. A lost or extra stage in the trigger pipeline moves or doubles the `bits_vld` pulse, and the per-cycle strobe check catches that at once. A controller that leaves FILL on the wrong count shows as a wrong `bits_unprimed` on the first trigger near the sixteenth sample. The bench fires triggers right around that boundary.

// File: rtl/corr_pkg.sv
package corr_pkg;
    typedef enum logic [0:0] {
        ST_FILL  = 1'b0,
        ST_READY = 1'b1
    } prime_state_t;

    function automatic int tree_levels(input int depth);
        return $clog2(depth);
    endfunction
endpackage

// File: rtl/corr_prime_fsm.sv
module corr_prime_fsm
    import corr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_vld,
    output logic primed
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    prime_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == ST_FILL && smp_vld) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL:  if (smp_vld && cnt_q == CNT_W'(DEPTH - 1)) state_d = ST_READY;
            ST_READY: state_d = ST_READY;
            default:  state_d = ST_FILL;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_FILL:  primed = 1'b0;
            ST_READY: primed = 1'b1;
            default:  primed = 1'b0;
        endcase
    end
endmodule

// File: rtl/corr_lane.sv
module corr_lane #(
    parameter int DEPTH = 16,
    parameter int IN_W  = 24,
    parameter int ACC_W = 28
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_vld,
    input  logic signed [IN_W-1:0]  in_re,
    input  logic signed [IN_W-1:0]  in_im,
    input  logic                    load,
    output logic                    bit_o,
    output logic [ACC_W-1:0]        sum_re,
    output logic [ACC_W-1:0]        sum_im
);
    localparam int GUARD = ACC_W - IN_W;
    localparam int NODES = 2 * DEPTH - 1;

    logic [IN_W-1:0]  hist_re [DEPTH];
    logic [IN_W-1:0]  hist_im [DEPTH];
    logic [ACC_W-1:0] node_re [NODES];
    logic [ACC_W-1:0] node_im [NODES];

    // history: index 0 newest
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                hist_re[i] <= '0;
                hist_im[i] <= '0;
            end
        end else if (smp_vld) begin
            hist_re[0] <= in_re;
            hist_im[0] <= in_im;
            for (int i = 1; i < DEPTH; i++) begin
                hist_re[i] <= hist_re[i-1];
                hist_im[i] <= hist_im[i-1];
            end
        end
    end

    // leaves of the heap-ordered tree, sign extended
    for (genvar i = 0; i < DEPTH; i++) begin : g_leaf
        assign node_re[DEPTH-1+i] = {{GUARD{hist_re[i][IN_W-1]}}, hist_re[i]};
        assign node_im[DEPTH-1+i] = {{GUARD{hist_im[i][IN_W-1]}}, hist_im[i]};
    end

    // internal nodes: one register per adder, one level per cycle
    for (genvar n = 0; n < DEPTH - 1; n++) begin : g_add
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                node_re[n] <= '0;
                node_im[n] <= '0;
            end else begin
                node_re[n] <= node_re[2*n+1] + node_re[2*n+2];
                node_im[n] <= node_im[2*n+1] + node_im[2*n+2];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_o  <= 1'b0;
            sum_re <= '0;
            sum_im <= '0;
        end else if (load) begin
            bit_o  <= ($signed(node_re[0]) > 0);
            sum_re <= node_re[0];
            sum_im <= node_im[0];
        end
    end
endmodule

// File: rtl/cplx_corr_decide.sv
module cplx_corr_decide
    import corr_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DEPTH = 16,
    parameter int IN_W  = 24,
    parameter int ACC_W = IN_W + $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   smp_vld,
    input  logic [LANES*IN_W-1:0]  smp_re,
    input  logic [LANES*IN_W-1:0]  smp_im,
    input  logic                   sum_go,
    output logic [LANES-1:0]       bits_out,
    output logic                   bits_vld,
    output logic                   bits_unprimed,
    output logic [LANES*ACC_W-1:0] corr_sum_re,
    output logic [LANES*ACC_W-1:0] corr_sum_im
);
    localparam int LEVELS = tree_levels(DEPTH);

    logic              primed;
    logic [LEVELS-1:0] go_pipe;
    logic [LEVELS-1:0] unp_pipe;
    logic              load;

    corr_prime_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_vld(smp_vld),
        .primed (primed)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_pipe  <= '0;
            unp_pipe <= '0;
        end else begin
            go_pipe  <= {go_pipe[LEVELS-2:0], sum_go};
            unp_pipe <= {unp_pipe[LEVELS-2:0], ~primed};
        end
    end

    assign load = go_pipe[LEVELS-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_vld      <= 1'b0;
            bits_unprimed <= 1'b0;
        end else begin
            bits_vld <= load;
            if (load) bits_unprimed <= unp_pipe[LEVELS-1];
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        corr_lane #(.DEPTH(DEPTH), .IN_W(IN_W), .ACC_W(ACC_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .smp_vld(smp_vld),
            .in_re  (smp_re[l*IN_W +: IN_W]),
            .in_im  (smp_im[l*IN_W +: IN_W]),
            .load   (load),
            .bit_o  (bits_out[l]),
            .sum_re (corr_sum_re[l*ACC_W +: ACC_W]),
            .sum_im (corr_sum_im[l*ACC_W +: ACC_W])
        );
    end
endmodule

// File: rtl/corr_decide_chk.sv
module corr_decide_chk #(
    parameter int LANES = 8,
    parameter int DEPTH = 16,
    parameter int ACC_W = 28
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sum_go,
    input logic [LANES-1:0]       bits_out,
    input logic                   bits_vld,
    input logic                   bits_unprimed,
    input logic [LANES*ACC_W-1:0] corr_sum_re
);
    localparam int LAT = $clog2(DEPTH) + 1;

    logic [LAT-1:0] go_hist;
    logic           seen_primed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_hist     <= '0;
            seen_primed <= 1'b0;
        end else begin
            go_hist <= {go_hist[LAT-2:0], sum_go};
            if (bits_vld && !bits_unprimed) seen_primed <= 1'b1;
        end
    end

    function automatic logic [LANES-1:0] signs(input logic [LANES*ACC_W-1:0] s);
        logic [LANES-1:0] r;
        for (int l = 0; l < LANES; l++) r[l] = ($signed(s[l*ACC_W +: ACC_W]) > 0);
        return r;
    endfunction

    // R5 R6 R9
    a_r5_strobe_latency: assert property (@(posedge clk) disable iff (!rst_n)
        bits_vld == go_hist[LAT-1]);
    a_r4_sign_slice: assert property (@(posedge clk) disable iff (!rst_n)
        bits_vld |-> bits_out == signs(corr_sum_re));
    a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !bits_vld |-> ($stable(bits_out) && $stable(bits_unprimed) && $stable(corr_sum_re)));
    a_r7_primed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (bits_vld && seen_primed) |-> !bits_unprimed);
    a_r8_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!bits_vld && bits_out == '0 && !bits_unprimed));
endmodule

bind cplx_corr_decide corr_decide_chk #(.LANES(LANES), .DEPTH(DEPTH), .ACC_W(ACC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sum_go       (sum_go),
    .bits_out     (bits_out),
    .bits_vld     (bits_vld),
    .bits_unprimed(bits_unprimed),
    .corr_sum_re  (corr_sum_re)
);

// File: tb/sim_cplx_corr_decide.sv
module sim_cplx_corr_decide;
    localparam int LANES = 8;
    localparam int DEPTH = 16;
    localparam int IN_W  = 24;
    localparam int ACC_W = 28;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_vld = 1'b0;
    logic sum_go = 1'b0;
    logic [LANES*IN_W-1:0]  smp_re = '0;
    logic [LANES*IN_W-1:0]  smp_im = '0;
    logic [LANES-1:0]       bits_out;
    logic                   bits_vld;
    logic                   bits_unprimed;
    logic [LANES*ACC_W-1:0] corr_sum_re;
    logic [LANES*ACC_W-1:0] corr_sum_im;

    always #10 clk = ~clk;

    cplx_corr_decide #(.LANES(LANES), .DEPTH(DEPTH), .IN_W(IN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_re(smp_re), .smp_im(smp_im),
        .sum_go(sum_go), .bits_out(bits_out), .bits_vld(bits_vld),
        .bits_unprimed(bits_unprimed), .corr_sum_re(corr_sum_re), .corr_sum_im(corr_sum_im)
    );

    int vectors = 0;
    int fails = 0;
    int ecount = 0;
    bit done = 0;

    always @(posedge clk) ecount <= ecount + 1;

    longint hre [LANES][DEPTH];
    longint him [LANES][DEPTH];
    int     accepted = 0;
    int     dre [LANES];
    int     dim [LANES];

    bit     pend [8];
    longint xre  [8][LANES];
    longint xim  [8][LANES];
    bit     xunp [8];
    logic [LANES-1:0] last_bits = '0;

    task automatic cmp(input string req, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, ecount);
        end
    endtask

    function automatic int rnd24();
        logic [23:0] r;
        r = 24'($urandom);
        return int'($signed(r));
    endfunction

    task automatic check_outputs();
        int s;
        s = ecount % 8;
        if (pend[s]) begin
            logic [LANES-1:0] eb;
            cmp("R5 R9 strobe", longint'(bits_vld), 1);
            cmp("R7 unprimed flag", longint'(bits_unprimed), longint'(xunp[s]));
            for (int l = 0; l < LANES; l++) begin
                eb[l] = (xre[s][l] > 0);
                cmp("R1 R2 R3 real sum", longint'($signed(corr_sum_re[l*ACC_W +: ACC_W])), xre[s][l]);
                cmp("R1 R2 R3 imag sum", longint'($signed(corr_sum_im[l*ACC_W +: ACC_W])), xim[s][l]);
            end
            cmp("R4 decided bits", longint'(bits_out), longint'(eb));
            last_bits = eb;
            pend[s] = 0;
        end else begin
            cmp("R6 no strobe", longint'(bits_vld), 0);
            cmp("R6 bits held", longint'(bits_out), longint'(last_bits));
        end
    endtask

    task automatic step(input bit v, input bit g);
        @(negedge clk);
        check_outputs();
        smp_vld = v;
        sum_go  = g;
        for (int l = 0; l < LANES; l++) begin
            smp_re[l*IN_W +: IN_W] = IN_W'(dre[l]);
            smp_im[l*IN_W +: IN_W] = IN_W'(dim[l]);
        end
        if (g) begin
            int s;
            s = (ecount + 5) % 8;
            pend[s] = 1;
            xunp[s] = (accepted < DEPTH);
            for (int l = 0; l < LANES; l++) begin
                xre[s][l] = 0;
                xim[s][l] = 0;
                for (int k = 0; k < DEPTH; k++) begin
                    xre[s][l] += hre[l][k];
                    xim[s][l] += him[l][k];
                end
            end
        end
        if (v) begin
            accepted++;
            for (int l = 0; l < LANES; l++) begin
                for (int k = DEPTH - 1; k > 0; k--) begin
                    hre[l][k] = hre[l][k-1];
                    him[l][k] = him[l][k-1];
                end
                hre[l][0] = dre[l];
                him[l][0] = dim[l];
            end
        end
    endtask

    task automatic fill_random();
        for (int l = 0; l < LANES; l++) begin
            dre[l] = rnd24();
            dim[l] = rnd24();
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_C0DE));
        for (int l = 0; l < LANES; l++) begin
            dre[l] = 0; dim[l] = 0;
            for (int k = 0; k < DEPTH; k++) begin hre[l][k] = 0; him[l][k] = 0; end
        end
        for (int i = 0; i < 8; i++) pend[i] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        cmp("R8 reset bits", longint'(bits_out), 0);
        cmp("R8 reset strobe", longint'(bits_vld), 0);
        cmp("R8 reset flag", longint'(bits_unprimed), 0);
        cmp("R8 reset sum", longint'(corr_sum_re[ACC_W-1:0]), 0);
        rst_n = 1'b1;

        // R7 R8: trigger with empty history, zero sums give 0 bits (R4)
        step(0, 1);
        repeat (6) step(0, 0);

        // R7: partially filled
        for (int i = 0; i < 10; i++) begin fill_random(); step(1, 0); end
        step(0, 1);
        // cross the sixteenth sample with triggers on each side (R7 boundary)
        for (int i = 0; i < 5; i++) begin fill_random(); step(1, 0); end
        fill_random(); step(1, 1);      // fifteen before this edge: unprimed, R5 exclusion
        fill_random(); step(1, 1);      // sixteen before this edge: primed
        repeat (6) step(0, 0);

        // R2: invalid cycles with noisy buses leave the history alone
        for (int i = 0; i < 6; i++) begin fill_random(); step(0, 0); end
        fill_random(); step(0, 1);
        repeat (6) step(0, 0);

        // R3: extremes
        for (int l = 0; l < LANES; l++) begin dre[l] = 8388607; dim[l] = -8388608; end
        repeat (16) step(1, 0);
        step(0, 1);
        for (int l = 0; l < LANES; l++) begin dre[l] = -8388608; dim[l] = 8388607; end
        repeat (16) step(1, 0);
        step(0, 1);
        repeat (6) step(0, 0);

        // R4: exact zero and smallest positive totals
        for (int k = 0; k < 16; k++) begin
            for (int l = 0; l < LANES; l++) begin
                case (l % 4)
                    0: dre[l] = (k % 2 == 0) ? 1000 : -1000;
                    1: dre[l] = (k == 3) ? 1 : 0;
                    2: dre[l] = (k == 3) ? -1 : 0;
                    default: dre[l] = (k % 2 == 0) ? -5 : 5;
                endcase
                dim[l] = k * 7 - l;
            end
            step(1, 0);
        end
        step(0, 1);
        repeat (6) step(0, 0);

        // R6: back-to-back triggers, then mixed random traffic
        for (int i = 0; i < 4; i++) begin fill_random(); step(1, 1); end
        for (int i = 0; i < 400; i++) begin
            fill_random();
            step(bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 4) == 0));
        end
        repeat (8) step(0, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule